// File: doc/BRIEF.md
# Transmit DMA Read Burst Generator

This block converts one transmit transfer request (a start address and a total number of data beats) into a sequence of memory read bursts for a single transmit DMA channel. The size of each burst comes from a 6-bit burst-length code. An optional times-eight mode multiplies that code. The result is capped at half of the transmit queue depth, which is computed from the queue size and the beat width. The block issues one burst request at a time, each carrying a start address, a beat count and a 4-bit quality-of-service tag. It waits for a grant before it moves to the next burst.

A transfer starts with a one-cycle pulse on `xfer_start_i` while the block is idle. The burst-length code, the times-eight bit and the QoS value are captured at that moment and are used for the whole transfer. Every burst except the last requests the full effective length. The last burst carries whatever beats remain. A burst-length code outside the supported set is refused: the error flag rises and no request is made. A transfer of zero beats completes at once.

Top module: `tx_burst_req_gen`

## Requirements
- R1: During and directly after reset, `rd_req_o`, `busy_o`, `done_o` and `cfg_err_o` are all 0.
- R2: A start while idle whose `cfg_pbl_i` is not one of 1, 2, 4, 8, 16 or 32 sets `cfg_err_o` to 1 from the next cycle. It issues no request, and `busy_o` stays 0. This includes the code 0.
- R3: The effective burst length is the value of `cfg_pbl_i` when `cfg_pblx8_i` is 0, and eight times that value when `cfg_pblx8_i` is 1.
- R4: The effective burst length never exceeds QUEUE_BYTES / BEAT_BYTES / 2 beats. A larger programmed length is reduced to that limit.
- R5: Every burst of a transfer has the full effective length except the last, which carries only the remaining beats. The lengths add up to the requested total, and no request has length 0.
- R6: The first burst address equals `xfer_addr_i`. Each later burst address is the previous one plus the previous length times BEAT_BYTES.
- R7: A request stays asserted with unchanged address, length and QoS until the cycle in which `rd_gnt_i` is high. After a grant, the next burst (if any) is presented in the following cycle.
- R8: `rd_qos_o` equals the `cfg_qos_i` value captured at the start, for every burst of that transfer.
- R9: In the cycle after the last burst is granted, `done_o` is 1 for one cycle, and `busy_o` and `rd_req_o` are 0.
- R10: A start pulse while a transfer is in progress is ignored; the current sequence of bursts continues unchanged.
- R11: A legal start with zero beats raises `done_o` for one cycle in the next cycle and issues no request.
- R12: A start with a legal code clears `cfg_err_o` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start_i | input | 1 | One-cycle transfer start pulse, taken only when idle |
| xfer_addr_i | input | ADDR_W | Byte address of the first beat |
| xfer_beats_i | input | CNT_W | Total beats to transfer |
| cfg_pbl_i | input | 6 | Burst-length code (1, 2, 4, 8, 16 or 32) |
| cfg_pblx8_i | input | 1 | Multiply the burst length by eight |
| cfg_qos_i | input | 4 | QoS value tagged onto every request of the transfer |
| rd_gnt_i | input | 1 | Bus grant for the pending request |
| rd_req_o | output | 1 | Burst request pending |
| rd_addr_o | output | ADDR_W | Start byte address of the pending burst |
| rd_len_o | output | 9 | Beat count of the pending burst |
| rd_qos_o | output | 4 | QoS tag of the pending burst |
| busy_o | output | 1 | A transfer is in progress |
| done_o | output | 1 | One-cycle pulse when a transfer completes |
| cfg_err_o | output | 1 | Last start used an unsupported burst-length code |

## Verification
The bench targets these corner cases:

- **Cap at half the queue depth.** It programs a length of 32 with times-eight mode, which must be cut to 128 beats. A design without the cap would request 256 beats and overrun the queue.
- **Short last burst.** It uses totals that are not multiples of the burst. A design that does not shorten the last burst would over-read past the end of the transfer.
- **Address and hold rules.** Grants are withheld at random. This exposes an address that advances by the wrong stride, and a request that changes before its grant.
- **Rejected and empty starts.** It tries illegal codes such as 0, 3 and 48, a zero-beat transfer, and a start pulse in the middle of a transfer. A design that gets these wrong would issue requests it should refuse, hang with no done pulse, or restart a transfer that is still running.

// File: rtl/tx_burst_pkg.sv
package tx_burst_pkg;
   localparam int PBL_W    = 6;
   localparam int QOS_W    = 4;
   localparam int X8_SHIFT = 3;
   // largest legal code is 2**(PBL_W-1); times eight gives the widest raw burst
   localparam int MAX_RAW  = (1 << (PBL_W - 1)) << X8_SHIFT;
   localparam int LEN_W    = $clog2(MAX_RAW + 1);

   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_ISSUE = 1'b1
   } gen_state_e;

   // a code is legal when exactly one bit is set
   function automatic logic code_is_legal(input logic [PBL_W-1:0] code);
      return (code != '0) && ((code & (code - 1'b1)) == '0);
   endfunction
endpackage

// File: rtl/tx_burst_sizer.sv
module tx_burst_sizer
   import tx_burst_pkg::*;
#(
   parameter int HALF_DEPTH = 128
) (
   input  logic [PBL_W-1:0] pbl_code_i,
   input  logic             x8_i,
   output logic             legal_o,
   output logic [LEN_W-1:0] eff_len_o
);
   logic [LEN_W-1:0] raw_len;

   always_comb begin
      legal_o = code_is_legal(pbl_code_i);
      raw_len = x8_i ? (LEN_W'(pbl_code_i) << X8_SHIFT) : LEN_W'(pbl_code_i);
   end

   generate
      if (HALF_DEPTH >= MAX_RAW) begin : g_nocap
         assign eff_len_o = raw_len;
      end else begin : g_cap
         localparam logic [LEN_W-1:0] CAP = LEN_W'(HALF_DEPTH);
         assign eff_len_o = (raw_len > CAP) ? CAP : raw_len;
      end
   endgenerate
endmodule

// File: rtl/tx_beat_tracker.sv
module tx_beat_tracker
   import tx_burst_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int CNT_W      = 16,
   parameter int BEAT_SHIFT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [CNT_W-1:0]  beats_i,
   input  logic [LEN_W-1:0]  eff_i,
   input  logic              adv_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [LEN_W-1:0]  len_o,
   output logic              last_o
);
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  rem_q;
   logic [LEN_W-1:0]  eff_q;
   logic [CNT_W-1:0]  eff_wide;

   always_comb begin
      eff_wide = CNT_W'(eff_q);
      len_o    = (rem_q < eff_wide) ? LEN_W'(rem_q) : eff_q;
      last_o   = (rem_q <= eff_wide);
      addr_o   = addr_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         rem_q  <= '0;
         eff_q  <= '0;
      end else if (load_i) begin
         addr_q <= addr_i;
         rem_q  <= beats_i;
         eff_q  <= eff_i;
      end else if (adv_i) begin
         addr_q <= addr_q + (ADDR_W'(len_o) << BEAT_SHIFT);
         rem_q  <= rem_q - CNT_W'(len_o);
      end
   end
endmodule

// File: rtl/tx_burst_req_gen.sv
module tx_burst_req_gen
   import tx_burst_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int CNT_W       = 16,
   parameter int BEAT_BYTES  = 8,
   parameter int QUEUE_BYTES = 2048
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer_start_i,
   input  logic [ADDR_W-1:0] xfer_addr_i,
   input  logic [CNT_W-1:0]  xfer_beats_i,
   input  logic [5:0]        cfg_pbl_i,
   input  logic              cfg_pblx8_i,
   input  logic [3:0]        cfg_qos_i,
   input  logic              rd_gnt_i,
   output logic              rd_req_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   output logic [8:0]        rd_len_o,
   output logic [3:0]        rd_qos_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              cfg_err_o
);
   localparam int BEAT_SHIFT  = $clog2(BEAT_BYTES);
   localparam int QUEUE_DEPTH = QUEUE_BYTES / BEAT_BYTES;
   localparam int HALF_DEPTH  = QUEUE_DEPTH / 2;

   generate
      if (BEAT_BYTES != (1 << BEAT_SHIFT)) begin : g_bad_beat
         $error("BEAT_BYTES must be a power of two");
      end
      if (HALF_DEPTH < 1) begin : g_bad_queue
         $error("queue must hold at least two beats");
      end
      if (CNT_W < LEN_W) begin : g_bad_cnt
         $error("CNT_W must be at least LEN_W");
      end
      if (LEN_W != 9 || PBL_W != 6 || QOS_W != 4) begin : g_bad_pkg
         $error("port widths disagree with package constants");
      end
   endgenerate

   gen_state_e       state_q;
   logic [QOS_W-1:0] qos_q;
   logic             err_q;
   logic             done_q;
   logic             code_ok;
   logic [LEN_W-1:0] eff_len;
   logic             accept;
   logic             load;
   logic             adv;
   logic             last_burst;
   logic [LEN_W-1:0] cur_len;
   logic [ADDR_W-1:0] cur_addr;

   tx_burst_sizer #(
      .HALF_DEPTH(HALF_DEPTH)
   ) sizer_i (
      .pbl_code_i(cfg_pbl_i),
      .x8_i      (cfg_pblx8_i),
      .legal_o   (code_ok),
      .eff_len_o (eff_len)
   );

   always_comb begin
      accept = xfer_start_i && (state_q == ST_IDLE);
      load   = accept && code_ok && (xfer_beats_i != '0);
      adv    = (state_q == ST_ISSUE) && rd_gnt_i;
   end

   tx_beat_tracker #(
      .ADDR_W    (ADDR_W),
      .CNT_W     (CNT_W),
      .BEAT_SHIFT(BEAT_SHIFT)
   ) trk_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .addr_i (xfer_addr_i),
      .beats_i(xfer_beats_i),
      .eff_i  (eff_len),
      .adv_i  (adv),
      .addr_o (cur_addr),
      .len_o  (cur_len),
      .last_o (last_burst)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         qos_q   <= '0;
         err_q   <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  err_q <= !code_ok;
                  if (code_ok) begin
                     qos_q <= cfg_qos_i;
                     if (xfer_beats_i == '0) begin
                        done_q <= 1'b1;
                     end else begin
                        state_q <= ST_ISSUE;
                     end
                  end
               end
            end
            ST_ISSUE: begin
               if (adv && last_burst) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      rd_req_o  = (state_q == ST_ISSUE);
      busy_o    = (state_q == ST_ISSUE);
      rd_addr_o = cur_addr;
      rd_len_o  = cur_len;
      rd_qos_o  = qos_q;
      done_o    = done_q;
      cfg_err_o = err_q;
   end
endmodule

// File: rtl/tx_burst_req_gen_chk.sv
module tx_burst_req_gen_chk #(
   parameter int ADDR_W      = 32,
   parameter int BEAT_BYTES  = 8,
   parameter int QUEUE_BYTES = 2048
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_req_o,
   input logic              rd_gnt_i,
   input logic [ADDR_W-1:0] rd_addr_o,
   input logic [8:0]        rd_len_o,
   input logic [3:0]        rd_qos_o,
   input logic              busy_o,
   input logic              done_o,
   input logic              cfg_err_o
);
   localparam int BEAT_SHIFT = $clog2(BEAT_BYTES);
   localparam int HALF_DEPTH = QUEUE_BYTES / BEAT_BYTES / 2;
   localparam int LEN_CAP    = (HALF_DEPTH < 256) ? HALF_DEPTH : 256;

   p_hold_until_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && !rd_gnt_i) |=> (rd_req_o && $stable(rd_addr_o) &&
                                   $stable(rd_len_o) && $stable(rd_qos_o)));

   p_len_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |-> ((rd_len_o != '0) && (int'(rd_len_o) <= LEN_CAP)));

   p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && rd_gnt_i) |=> (!rd_req_o ||
         (rd_addr_o == ADDR_W'($past(rd_addr_o) + (ADDR_W'($past(rd_len_o)) << BEAT_SHIFT)))));

   p_qos_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && rd_gnt_i) |=> (!rd_req_o || $stable(rd_qos_o)));

   p_err_no_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err_o |-> (!rd_req_o && !busy_o));

   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && !rd_req_o));
endmodule

bind tx_burst_req_gen tx_burst_req_gen_chk #(
   .ADDR_W     (ADDR_W),
   .BEAT_BYTES (BEAT_BYTES),
   .QUEUE_BYTES(QUEUE_BYTES)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .rd_req_o (rd_req_o),
   .rd_gnt_i (rd_gnt_i),
   .rd_addr_o(rd_addr_o),
   .rd_len_o (rd_len_o),
   .rd_qos_o (rd_qos_o),
   .busy_o   (busy_o),
   .done_o   (done_o),
   .cfg_err_o(cfg_err_o)
);

// File: tb/tx_burst_req_gen_tb_top.sv
`timescale 1ns/1ps
module tx_burst_req_gen_tb_top;
   localparam int ADDR_W      = 32;
   localparam int CNT_W       = 16;
   localparam int BEAT_BYTES  = 8;
   localparam int QUEUE_BYTES = 2048;
   localparam int HALF        = QUEUE_BYTES / BEAT_BYTES / 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              xfer_start_i = 1'b0;
   logic [ADDR_W-1:0] xfer_addr_i = '0;
   logic [CNT_W-1:0]  xfer_beats_i = '0;
   logic [5:0]        cfg_pbl_i = '0;
   logic              cfg_pblx8_i = 1'b0;
   logic [3:0]        cfg_qos_i = '0;
   logic              rd_gnt_i = 1'b0;
   logic              rd_req_o;
   logic [ADDR_W-1:0] rd_addr_o;
   logic [8:0]        rd_len_o;
   logic [3:0]        rd_qos_o;
   logic              busy_o;
   logic              done_o;
   logic              cfg_err_o;

   int n_chk  = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   tx_burst_req_gen #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BEAT_BYTES(BEAT_BYTES), .QUEUE_BYTES(QUEUE_BYTES)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .xfer_start_i(xfer_start_i), .xfer_addr_i(xfer_addr_i),
      .xfer_beats_i(xfer_beats_i), .cfg_pbl_i(cfg_pbl_i), .cfg_pblx8_i(cfg_pblx8_i),
      .cfg_qos_i(cfg_qos_i), .rd_gnt_i(rd_gnt_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
      .rd_len_o(rd_len_o), .rd_qos_o(rd_qos_o), .busy_o(busy_o), .done_o(done_o),
      .cfg_err_o(cfg_err_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_eff(input int pbl, input bit x8);
      int raw;
      raw = x8 ? pbl * 8 : pbl;
      return (raw > HALF) ? HALF : raw;
   endfunction

   task automatic start_pulse(input logic [31:0] a, input int beats, input int pbl,
                              input bit x8, input int qos);
      @(negedge clk);
      xfer_start_i = 1'b1;
      xfer_addr_i  = a;
      xfer_beats_i = CNT_W'(beats);
      cfg_pbl_i    = 6'(pbl);
      cfg_pblx8_i  = x8;
      cfg_qos_i    = 4'(qos);
      rd_gnt_i     = 1'b0;
      @(negedge clk);
      xfer_start_i = 1'b0;
   endtask

   // runs a legal transfer with random grant gaps and checks every burst
   task automatic run_xfer(input logic [31:0] a, input int beats, input int pbl,
                           input bit x8, input int qos, input bit poke);
      int          rem;
      int          eff;
      int          elen;
      int          guard;
      int          total;
      bit          poked;
      bit          g;
      logic [31:0] ea;
      rem = beats; eff = exp_eff(pbl, x8); guard = 0; total = 0; poked = 0; ea = a;
      start_pulse(a, beats, pbl, x8, qos);
      chk(cfg_err_o == 1'b0, "R12", "err after legal start", cfg_err_o, 0);
      while (rem > 0 && guard < 5000) begin
         guard++;
         elen = (rem < eff) ? rem : eff;
         chk(rd_req_o == 1'b1 && busy_o == 1'b1, "R7", "request pending", rd_req_o, 1);
         chk(int'(rd_len_o) == elen, "R5", "burst length (R3/R4)", rd_len_o, elen);
         chk(rd_addr_o == ea, "R6", "burst address", rd_addr_o, ea);
         chk(int'(rd_qos_o) == qos, "R8", "qos tag", rd_qos_o, qos);
         g = ($urandom_range(0, 3) != 0);
         if (!g && poke && !poked) begin
            xfer_start_i = 1'b1;           // R10: ignored while busy
            xfer_addr_i  = ~a;
            xfer_beats_i = 16'd5;
            cfg_pbl_i    = 6'd1;
            cfg_qos_i    = 4'(~qos);
            poked        = 1'b1;
         end
         rd_gnt_i = g;
         @(negedge clk);
         xfer_start_i = 1'b0;
         rd_gnt_i     = 1'b0;
         if (g) begin
            rem   -= elen;
            total += elen;
            ea    += 32'(elen * BEAT_BYTES);
         end
      end
      chk(total == beats, "R5", "beats summed", total, beats);
      chk(done_o == 1'b1, "R9", "done after last grant", done_o, 1);
      chk(busy_o == 1'b0 && rd_req_o == 1'b0, "R9", "idle after last grant", busy_o, 0);
      @(negedge clk);
      chk(done_o == 1'b0, "R9", "done is one cycle", done_o, 0);
   endtask

   task automatic bad_code(input int pbl);
      start_pulse(32'h40, 10, pbl, 1'b0, 3);
      chk(cfg_err_o == 1'b1, "R2", "err on illegal code", cfg_err_o, 1);
      repeat (3) begin
         chk(rd_req_o == 1'b0 && busy_o == 1'b0, "R2", "no request on illegal code", rd_req_o, 0);
         @(negedge clk);
      end
      chk(done_o == 1'b0, "R2", "no done on illegal code", done_o, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      chk(rd_req_o == 1'b0 && busy_o == 1'b0, "R1", "idle in reset", rd_req_o, 0);
      chk(done_o == 1'b0 && cfg_err_o == 1'b0, "R1", "flags in reset", done_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rd_req_o == 1'b0 && busy_o == 1'b0 && cfg_err_o == 1'b0, "R1", "idle after reset",
          rd_req_o, 0);

      run_xfer(32'h1000, 20, 8, 1'b0, 5, 1'b0);    // R3: 8,8,4
      run_xfer(32'h2000, 70, 4, 1'b1, 9, 1'b1);    // R3 x8: 32,32,6 ; R10 poke
      run_xfer(32'h8000, 300, 32, 1'b1, 15, 1'b0); // R4: capped 128,128,44
      run_xfer(32'h0, 3, 1, 1'b0, 0, 1'b1);        // R5 single beats
      run_xfer(32'hFFFF_FF00, 40, 16, 1'b0, 7, 1'b0); // R6 address wrap

      bad_code(0);
      bad_code(3);
      bad_code(48);
      run_xfer(32'h3000, 33, 2, 1'b1, 12, 1'b0);   // R12 clears err

      start_pulse(32'h500, 0, 4, 1'b0, 1);          // R11
      chk(done_o == 1'b1, "R11", "done on zero beats", done_o, 1);
      chk(rd_req_o == 1'b0 && busy_o == 1'b0, "R11", "no request on zero beats", rd_req_o, 0);
      @(negedge clk);
      chk(done_o == 1'b0 && rd_req_o == 1'b0, "R11", "quiet after zero beats", done_o, 0);

      for (int i = 0; i < 25; i++) begin
         int          pbl;
         bit          x8;
         int          beats;
         int          qos;
         logic [31:0] a;
         pbl   = 1 << $urandom_range(0, 5);
         x8    = $urandom_range(0, 1) != 0;
         beats = $urandom_range(1, 400);
         qos   = $urandom_range(0, 15);
         a     = $urandom() & 32'hFFFF_FFF8;
         run_xfer(a, beats, pbl, x8, qos, ($urandom_range(0, 1) != 0));
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule